// File: doc/BRIEF.md
# External Interrupt Sense Converter

This peripheral sits between a bank of external interrupt pins and an upstream interrupt controller that only accepts active-high level requests. Each of the 32 lines can be set independently to sense a rising edge, a falling edge, a high level or a low level. Whatever sense is chosen, the line leaves the block as an active-high level request. Edge events are held in a sticky latch until software discards them. Level requests follow the pin directly.

Software controls the block through a small single-cycle bus with a byte address, a write strobe and 32-bit data. There is one bit per line in every register. Writes take effect at the clock edge that samples the strobe. Read data is combinational from the addressed register. Register map (byte offsets): mask 0x00, polarity 0x04, edge select 0x08, raw status 0x0C (read only), request clear 0x10 (write only). Any other offset reads zero and ignores writes.

Top module: `extint_sense_conv`

## Requirements
- R1: After reset the mask register (0x00) reads all ones, the polarity (0x04) and edge-select (0x08) registers read zero, and every request output is low.
- R2: A mask bit of 1 forces that line's request output low, and a 0 lets the raw request through. The mask register reads back what was last written.
- R3: A polarity bit of 1 selects rising-edge or high-level sensing for its line, and a 0 selects falling-edge or low-level sensing.
- R4: An edge-select bit of 1 puts its line in edge mode, and a 0 puts it in level mode.
- R5: In edge mode a detected edge sets a latch that stays set until a 1 is written to that line's bit at offset 0x10. Writing 0 leaves the latch alone, and offset 0x10 reads zero.
- R6: In level mode the raw request equals the synchronized input after the polarity is applied, with no latching. A clear write has no lasting effect on it.
- R7: Offset 0x0C reads the raw requests of all lines before masking. Writes to it change no register.
- R8: An edge latches even while its line is masked. A clear issued before unmasking stops the stale event from reaching the output.
- R9: When a clear write and a newly detected edge hit the same line in the same cycle, the latch ends up set.
- R10: Inputs pass through a two-flop synchronizer. In level mode a pin change shows on the output after exactly two rising clock edges. In edge mode it shows after three.
- R11: Lines are independent: a write or an event on one line leaves the requests of the other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 32 | External interrupt pins, asynchronous |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| irq_req_o | output | 32 | Active-high level requests to the upstream controller |

## Verification
A request clear and a freshly detected edge on the same line can land in the same clock cycle. The bench provokes this by timing the pin change so that the write strobe reaches the clear register at the exact edge where the synchronized edge is detected. It then expects the raw status bit to read 1. A control case on a neighbouring line sends the same clear one cycle later and expects that bit to read 0. Together the two cases show that the priority comes from the latch logic and not from the order of the accesses.

// File: rtl/eisc_pkg.sv
package eisc_pkg;

    // Byte offsets of the software-visible registers.
    localparam int unsigned OFS_MASK  = 32'h00;
    localparam int unsigned OFS_POL   = 32'h04;
    localparam int unsigned OFS_EDGE  = 32'h08;
    localparam int unsigned OFS_RAW   = 32'h0C;
    localparam int unsigned OFS_CLR   = 32'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_POL,
        SEL_EDGE,
        SEL_RAW,
        SEL_CLR
    } reg_sel_e;

endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][LINES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/eisc_line_det.sv
module eisc_line_det #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] sync_i,
    input  logic [LINES-1:0] pol_i,
    input  logic [LINES-1:0] edge_sel_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] raw_o
);

    typedef struct packed {
        logic [LINES-1:0] prev;
        logic [LINES-1:0] held;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [LINES-1:0] hit;
    logic [LINES-1:0] lvl;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Polarity folds the sense into an active-high view of the pin.
        assign lvl[g] = pol_i[g] ? sync_i[g] : ~sync_i[g];
        assign hit[g] = pol_i[g] ? (sync_i[g] & ~st_q.prev[g])
                                 : (~sync_i[g] & st_q.prev[g]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
        // A fresh edge outranks a clear in the same cycle; level lines hold nothing.
        st_d.held = edge_sel_i & (hit | (st_q.held & ~clr_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = (edge_sel_i & st_q.held) | (~edge_sel_i & lvl);

endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
    import eisc_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINES-1:0]  wdata_i,
    input  logic [LINES-1:0]  raw_i,
    output logic [LINES-1:0]  rdata_o,
    output logic [LINES-1:0]  mask_o,
    output logic [LINES-1:0]  pol_o,
    output logic [LINES-1:0]  edge_sel_o,
    output logic [LINES-1:0]  clr_o
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] edg;
    } cfg_t;

    cfg_t     st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        case (addr_i)
            A_MASK:  sel = SEL_MASK;
            A_POL:   sel = SEL_POL;
            A_EDGE:  sel = SEL_EDGE;
            A_RAW:   sel = SEL_RAW;
            A_CLR:   sel = SEL_CLR;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (wr_i) begin
            case (sel)
                SEL_MASK: st_d.mask = wdata_i;
                SEL_POL:  st_d.pol  = wdata_i;
                SEL_EDGE: st_d.edg  = wdata_i;
                SEL_CLR:  clr_o     = wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MASK: rdata_o = st_q.mask;
            SEL_POL:  rdata_o = st_q.pol;
            SEL_EDGE: rdata_o = st_q.edg;
            SEL_RAW:  rdata_o = raw_i;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= '1;
            st_q.pol  <= '0;
            st_q.edg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o     = st_q.mask;
    assign pol_o      = st_q.pol;
    assign edge_sel_o = st_q.edg;

endmodule

// File: rtl/extint_sense_conv.sv
module extint_sense_conv #(
    parameter int unsigned LINES       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINES-1:0]  ext_irq_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    output logic [LINES-1:0]  bus_rdata_o,
    output logic [LINES-1:0]  irq_req_o
);

    logic [LINES-1:0] sync_w;
    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] mask_w;
    logic [LINES-1:0] pol_w;
    logic [LINES-1:0] edge_sel_w;
    logic [LINES-1:0] clr_w;

    eisc_sync #(
        .LINES  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_irq_i),
        .sync_o  (sync_w)
    );

    eisc_line_det #(
        .LINES (LINES)
    ) u_det (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_w),
        .pol_i      (pol_w),
        .edge_sel_i (edge_sel_w),
        .clr_i      (clr_w),
        .raw_o      (raw_w)
    );

    eisc_regs #(
        .LINES  (LINES),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .raw_i      (raw_w),
        .rdata_o    (bus_rdata_o),
        .mask_o     (mask_w),
        .pol_o      (pol_w),
        .edge_sel_o (edge_sel_w),
        .clr_o      (clr_w)
    );

    assign irq_req_o = raw_w & ~mask_w;

endmodule

// File: rtl/eisc_checker.sv
module eisc_checker
    import eisc_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [LINES-1:0]  bus_wdata_i,
    input logic [LINES-1:0]  irq_req_o,
    input logic [LINES-1:0]  mask_i,
    input logic [LINES-1:0]  edge_sel_i,
    input logic [LINES-1:0]  raw_i
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);

    p_mask_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o & mask_i) == '0);

    p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_MASK) |=> (mask_i == $past(bus_wdata_i)));

    p_edge_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_EDGE) |=> (edge_sel_i == $past(bus_wdata_i)));

    p_edge_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_wr_i |=> ((($past(raw_i) & edge_sel_i) & ~raw_i) == '0));

    p_raw_readonly_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_RAW) |=> ($stable(mask_i) && $stable(edge_sel_i)));

endmodule

bind extint_sense_conv eisc_checker #(
    .LINES  (LINES),
    .ADDR_W (ADDR_W)
) u_eisc_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_req_o   (irq_req_o),
    .mask_i      (mask_w),
    .edge_sel_i  (edge_sel_w),
    .raw_i       (raw_w)
);

// File: tb/test_extint_sense_conv.sv
`timescale 1ns/1ps
module test_extint_sense_conv;

    localparam logic [7:0] A_MASK = 8'h00;
    localparam logic [7:0] A_POL  = 8'h04;
    localparam logic [7:0] A_EDGE = 8'h08;
    localparam logic [7:0] A_RAW  = 8'h0C;
    localparam logic [7:0] A_CLR  = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ext_irq = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    extint_sense_conv i_extint_sense_conv (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ext_irq_i   (ext_irq),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_req_o   (irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_MASK, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
        bus_read(A_POL, v);  chk("R1 polarity reset", v, 32'h0);
        bus_read(A_EDGE, v); chk("R1 edge reset", v, 32'h0);
        chk("R1 outputs low", irq_req, 32'h0);
        // Level-low default with pins low: every raw request set.
        bus_read(A_RAW, v);  chk("R7 raw after reset", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk); ext_irq = 32'hFFFF_FFFF;
        bus_write(A_POL, 32'h0000_00FF);
        bus_write(A_MASK, 32'h0);
        settle(3);
        chk("R3 R6 high/low level mix", irq_req, 32'h0000_00FF);
        ext_irq = 32'h0000_000F;
        settle(3);
        chk("R6 level follows pin", irq_req, 32'hFFFF_FF0F);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        settle(1);
        chk("R6 clear no lasting effect", irq_req, 32'hFFFF_FF0F);
        bus_write(A_RAW, 32'h0);
        bus_read(A_MASK, v); chk("R7 raw write ignored mask", v, 32'h0);
        bus_read(A_RAW, v);  chk("R7 raw status", v, 32'hFFFF_FF0F);
        bus_read(A_CLR, v);  chk("R5 clear reads zero", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(A_MASK, 32'hFFFF_0000);
        bus_read(A_MASK, v); chk("R2 mask readback", v, 32'hFFFF_0000);
        chk("R2 masked output", irq_req, 32'h0000_FF0F);
        bus_read(A_RAW, v);  chk("R7 raw unmasked", v, 32'hFFFF_FF0F);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        @(negedge clk); ext_irq = 32'h0;
        bus_write(A_POL, 32'h0000_FFFF);
        bus_write(A_EDGE, 32'hFFFF_FFFF);
        bus_write(A_MASK, 32'h0);
        settle(3);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        chk("R4 edge mode idle", irq_req, 32'h0);
        ext_irq = 32'h0000_00F0;
        settle(3);
        chk("R3 rising edge latched", irq_req, 32'h0000_00F0);
        ext_irq = 32'h0;
        settle(3);
        chk("R5 latch sticky after pin drop", irq_req, 32'h0000_00F0);
        ext_irq = 32'h00F0_0000;
        settle(3);
        chk("R3 rise ignored on falling lines", irq_req, 32'h0000_00F0);
        ext_irq = 32'h0;
        settle(3);
        chk("R3 falling edge latched", irq_req, 32'h00F0_00F0);
        bus_write(A_CLR, 32'h0);
        chk("R5 write zero no effect", irq_req, 32'h00F0_00F0);
        bus_write(A_CLR, 32'h0000_00F0);
        bus_read(A_RAW, v);
        chk("R5 R11 selective clear", v, 32'h00F0_0000);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        chk("R5 full clear", irq_req, 32'h0);
    endtask

    task automatic t_masked_latch();
        logic [31:0] v;
        bus_write(A_MASK, 32'hFFFF_FFFF);
        @(negedge clk); ext_irq = 32'h0000_0001;
        settle(3);
        chk("R8 masked output low", irq_req, 32'h0);
        bus_read(A_RAW, v); chk("R8 latched while masked", v, 32'h0000_0001);
        bus_write(A_CLR, 32'h0000_0001);
        bus_write(A_MASK, 32'h0);
        settle(1);
        chk("R8 stale event dropped", irq_req, 32'h0);
        ext_irq = 32'h0;
        settle(3);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk); ext_irq = 32'h0000_0002;
        @(negedge clk);
        bus_write(A_CLR, 32'h0000_0002);   // sampled on the edge that detects the rise
        bus_read(A_RAW, v);
        chk("R9 edge wins over clear", v, 32'h0000_0002);
        @(negedge clk); ext_irq = 32'h0000_0006;
        @(negedge clk);
        @(negedge clk);
        bus_write(A_CLR, 32'h0000_0004);   // one cycle after the latch set
        bus_read(A_RAW, v);
        chk("R9 R11 late clear removes only its line", v, 32'h0000_0002);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        ext_irq = 32'h0;
        settle(3);
    endtask

    task automatic t_latency();
        bus_write(A_EDGE, 32'h0);
        bus_write(A_POL, 32'hFFFF_FFFF);
        settle(3);
        chk("R10 level idle", irq_req, 32'h0);
        ext_irq = 32'h0000_0008;
        @(negedge clk);
        chk("R10 after one edge", irq_req, 32'h0);
        @(negedge clk);
        chk("R10 after two edges", irq_req, 32'h0000_0008);
        ext_irq = 32'h0;
        bus_write(A_EDGE, 32'h0000_0010);
        settle(3);
        ext_irq = 32'h0000_0010;
        @(negedge clk);
        @(negedge clk);
        chk("R10 edge after two edges", irq_req, 32'h0);
        @(negedge clk);
        chk("R10 edge after three edges", irq_req, 32'h0000_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_mask();
        t_edge();
        t_masked_latch();
        t_collide();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule